// File: doc/BRIEF.md
# Floating-Point Status, Control and Exception-Address Registers

This block holds the architectural state that sits beside a floating-point datapath: a 32-bit status register, a 16-bit control register and a 24-bit exception-address register. Each retiring floating-point instruction presents its exception flags, its address and, for compare and test instructions, a small result field. The block folds this information into the status register. It keeps a per-instruction flag view and a cumulative sticky view side by side.

The control register drives the datapath settings: per-exception masks, the rounding mode, flush-to-zero for subnormal results and zero treatment of subnormal operands. The block raises a same-cycle indication whenever a retiring instruction reports an exception whose mask is clear. Software reads all three registers directly. It writes the two halves of the status register under separate enables, writes the control register, and writes the address register to re-arm capture of the first exceptional address.

Top module: `fpu_csr`

## Requirements
- R1: On every retire (`rt_valid`=1), status bits [6:0] take `rt_flags`. An unflagged retire therefore clears them. Without a retire they hold.
- R2: Status bits [14:8] become their old value ORed with `rt_flags` on each retire. Only a software write of the lower status half changes them otherwise.
- R3: A retire with `rt_is_cmp`=1 loads `rt_cmp` into status bits [19:16]. A retire with `rt_is_tst`=1 loads `rt_tst` into status bits [28:24]. Without these strobes, both fields hold.
- R4: Control bits [6:0] are exception masks (1 = masked), bits [9:8] are the rounding mode (00 = round-to-nearest-even), bit 10 is flush-to-zero and bit 11 is subnormals-are-zero. They appear on `exc_mask`, `round_mode`, `ftz` and `saz`. After reset the control register reads 0x007F.
- R5: After reset the status register reads 0, the address register reads 0 and `exc_addr_vld` is 0. The first retire that has any flag set while `exc_addr_vld`=0 loads `rt_addr` and sets `exc_addr_vld`. Later exceptional retires leave the address unchanged.
- R6: A software write of the address register loads `sw_addr_wdata` and clears `exc_addr_vld`, which re-arms capture. The write wins over a capture in the same cycle.
- R7: `sw_stat_wr_lo` writes status bits [15:0] and `sw_stat_wr_hi` writes bits [31:16] from `sw_stat_wdata`. Each half is written independently of the other.
- R8: When a software write and a retire update the same status field in one cycle, the software value is stored. Fields outside the written half still take the retire update.
- R9: Status bits 7, 15, [23:20] and [31:29] and control bits [15:12] always read 0, whatever is written.
- R10: `exc_unmasked` is 1 in a cycle where `rt_valid`=1 and some bit of `rt_flags` is set whose `exc_mask` bit is 0. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_valid | input | 1 | A floating-point instruction retires this cycle |
| rt_flags | input | 7 | Exception flags of the retiring instruction |
| rt_addr | input | 24 | Address of the retiring instruction |
| rt_is_cmp | input | 1 | Retiring instruction is a compare |
| rt_cmp | input | 4 | Compare result |
| rt_is_tst | input | 1 | Retiring instruction is a test |
| rt_tst | input | 5 | Test result |
| sw_stat_wr_lo | input | 1 | Software write of status bits [15:0] |
| sw_stat_wr_hi | input | 1 | Software write of status bits [31:16] |
| sw_stat_wdata | input | 32 | Status write data |
| sw_ctrl_wr | input | 1 | Software write of the control register |
| sw_ctrl_wdata | input | 16 | Control write data |
| sw_addr_wr | input | 1 | Software write of the address register (re-arms capture) |
| sw_addr_wdata | input | 24 | Address write data |
| stat_q | output | 32 | Status register |
| ctrl_q | output | 16 | Control register |
| exc_addr_q | output | 24 | Captured exception address |
| exc_addr_vld | output | 1 | Captured address is meaningful |
| exc_mask | output | 7 | Exception masks |
| round_mode | output | 2 | Rounding mode |
| ftz | output | 1 | Flush-to-zero enable |
| saz | output | 1 | Subnormals-are-zero enable |
| exc_unmasked | output | 1 | Retiring instruction raised an unmasked exception |

## Verification
The hardest situations to reach are the same-cycle collisions: a half write of the status register that lands together with a flagged retire, and a re-arm write that lands together with an exceptional retire. In both, the written field must take the software value while the other fields still take the retire update. The stimulus drives the two sources in the same cycle, with compare and test strobes set, so that both halves change at once. It then sends a further flagged retire to show that capture was re-armed rather than frozen. The unmasked-exception indication can only be tested after the control register has cleared some masks. The stimulus therefore clears some masks first, then sends flags on both masked and unmasked positions.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;
  parameter int unsigned NFLAG   = 7;
  parameter int unsigned ADDR_W  = 24;
  parameter int unsigned CMP_W   = 4;
  parameter int unsigned TST_W   = 5;
  parameter int unsigned STAT_W  = 32;
  parameter int unsigned CTRL_W  = 16;
  parameter int unsigned HALF_W  = STAT_W / 2;
  // field positions inside the status register
  localparam int unsigned ST_RECENT_LSB = 0;
  localparam int unsigned ST_STICKY_LSB = 8;
  localparam int unsigned ST_CMP_LSB    = 16;
  localparam int unsigned ST_TST_LSB    = 24;
  // field positions inside the control register
  localparam int unsigned CT_RM_LSB  = 8;
  localparam int unsigned CT_FTZ_BIT = 10;
  localparam int unsigned CT_SAZ_BIT = 11;
  localparam int unsigned CT_USED_W  = 12;
endpackage

// File: rtl/fpu_csr_rst_sync.sv
module fpu_csr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fpu_csr_stat.sv
module fpu_csr_stat
  import fpu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic [NFLAG-1:0]  rt_flags,
  input  logic              rt_is_cmp,
  input  logic [CMP_W-1:0]  rt_cmp,
  input  logic              rt_is_tst,
  input  logic [TST_W-1:0]  rt_tst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat_q
);
  logic [NFLAG-1:0] recent_q, recent_d;
  logic [NFLAG-1:0] sticky_q, sticky_d;
  logic [CMP_W-1:0] cmp_q, cmp_d;
  logic [TST_W-1:0] tst_q, tst_d;

  always_comb begin
    recent_d = recent_q;
    sticky_d = sticky_q;
    cmp_d    = cmp_q;
    tst_d    = tst_q;
    if (rt_valid) begin
      recent_d = rt_flags;
      sticky_d = sticky_q | rt_flags;
      if (rt_is_cmp) cmp_d = rt_cmp;
      if (rt_is_tst) tst_d = rt_tst;
    end
    if (wr_lo) begin
      recent_d = wdata[ST_RECENT_LSB +: NFLAG];
      sticky_d = wdata[ST_STICKY_LSB +: NFLAG];
    end
    if (wr_hi) begin
      cmp_d = wdata[ST_CMP_LSB +: CMP_W];
      tst_d = wdata[ST_TST_LSB +: TST_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recent_q <= '0;
      sticky_q <= '0;
      cmp_q    <= '0;
      tst_q    <= '0;
    end else begin
      recent_q <= recent_d;
      sticky_q <= sticky_d;
      cmp_q    <= cmp_d;
      tst_q    <= tst_d;
    end
  end

  always_comb begin
    stat_q = '0;
    stat_q[ST_RECENT_LSB +: NFLAG] = recent_q;
    stat_q[ST_STICKY_LSB +: NFLAG] = sticky_q;
    stat_q[ST_CMP_LSB +: CMP_W]    = cmp_q;
    stat_q[ST_TST_LSB +: TST_W]    = tst_q;
  end

  // R1: a retire without a lower-half write leaves exactly its flags
  a_r1_recent_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && !wr_lo) |=> (stat_q[ST_RECENT_LSB +: NFLAG] == $past(rt_flags)));
  // R2: without a lower-half write no sticky bit is lost
  a_r2_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> ((stat_q[ST_STICKY_LSB +: NFLAG] & $past(stat_q[ST_STICKY_LSB +: NFLAG]))
                == $past(stat_q[ST_STICKY_LSB +: NFLAG])));
  // R8: software value wins on the upper half
  a_r8_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (stat_q[ST_CMP_LSB +: CMP_W] == $past(wdata[ST_CMP_LSB +: CMP_W])));
endmodule

// File: rtl/fpu_csr_ctrl.sv
module fpu_csr_ctrl
  import fpu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CT_USED_W-1:0] used_q, used_d;

  always_comb begin
    used_d = used_q;
    if (wr) used_d = wdata[CT_USED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= CT_USED_W'({NFLAG{1'b1}});
    else        used_q <= used_d;
  end

  assign ctrl_q = CTRL_W'(used_q);

  // R4: without a write the control register is held
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/fpu_csr_addr.sv
module fpu_csr_addr
  import fpu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic [NFLAG-1:0]  rt_flags,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              vld_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              vld_d;
  logic              capture;

  assign capture = rt_valid && (|rt_flags) && !vld_q;

  always_comb begin
    addr_d = addr_q;
    vld_d  = vld_q;
    if (wr) begin
      addr_d = wdata;
      vld_d  = 1'b0;
    end else if (capture) begin
      addr_d = rt_addr;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  // R5: once valid, the address holds until software writes it
  a_r5_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !wr) |=> ($stable(addr_q) && vld_q));
  // R5: an exceptional retire while armed is captured
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_q && rt_valid && (rt_flags != '0) && !wr) |=> (vld_q && addr_q == $past(rt_addr)));
  // R6: a software write re-arms
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!vld_q && addr_q == $past(wdata)));
endmodule

// File: rtl/fpu_csr.sv
module fpu_csr
  import fpu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic [NFLAG-1:0]  rt_flags,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_is_cmp,
  input  logic [CMP_W-1:0]  rt_cmp,
  input  logic              rt_is_tst,
  input  logic [TST_W-1:0]  rt_tst,
  input  logic              sw_stat_wr_lo,
  input  logic              sw_stat_wr_hi,
  input  logic [STAT_W-1:0] sw_stat_wdata,
  input  logic              sw_ctrl_wr,
  input  logic [CTRL_W-1:0] sw_ctrl_wdata,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr_wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [ADDR_W-1:0] exc_addr_q,
  output logic              exc_addr_vld,
  output logic [NFLAG-1:0]  exc_mask,
  output logic [1:0]        round_mode,
  output logic              ftz,
  output logic              saz,
  output logic              exc_unmasked
);
  logic rst_ns;

  fpu_csr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  fpu_csr_stat u_stat (
    .clk(clk), .rst_n(rst_ns), .rt_valid(rt_valid), .rt_flags(rt_flags),
    .rt_is_cmp(rt_is_cmp), .rt_cmp(rt_cmp), .rt_is_tst(rt_is_tst), .rt_tst(rt_tst),
    .wr_lo(sw_stat_wr_lo), .wr_hi(sw_stat_wr_hi), .wdata(sw_stat_wdata),
    .stat_q(stat_q));

  fpu_csr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_ns), .wr(sw_ctrl_wr), .wdata(sw_ctrl_wdata),
    .ctrl_q(ctrl_q));

  fpu_csr_addr u_addr (
    .clk(clk), .rst_n(rst_ns), .rt_valid(rt_valid), .rt_flags(rt_flags),
    .rt_addr(rt_addr), .wr(sw_addr_wr), .wdata(sw_addr_wdata),
    .addr_q(exc_addr_q), .vld_q(exc_addr_vld));

  assign exc_mask     = ctrl_q[NFLAG-1:0];
  assign round_mode   = ctrl_q[CT_RM_LSB +: 2];
  assign ftz          = ctrl_q[CT_FTZ_BIT];
  assign saz          = ctrl_q[CT_SAZ_BIT];
  assign exc_unmasked = rt_valid && (|(rt_flags & ~exc_mask));

  // R10: never raised without a retire
  a_r10_needs_retire: assert property (@(posedge clk) disable iff (!rst_ns)
    exc_unmasked |-> rt_valid);
  // R10: all flags masked means no indication
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    ((rt_flags & ~ctrl_q[NFLAG-1:0]) == '0) |-> !exc_unmasked);
endmodule

// File: tb/fpu_csr_bench.sv
module fpu_csr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        rt_valid = 0, rt_is_cmp = 0, rt_is_tst = 0;
  logic [6:0]  rt_flags = 0;
  logic [23:0] rt_addr = 0;
  logic [3:0]  rt_cmp = 0;
  logic [4:0]  rt_tst = 0;
  logic        sw_stat_wr_lo = 0, sw_stat_wr_hi = 0, sw_ctrl_wr = 0, sw_addr_wr = 0;
  logic [31:0] sw_stat_wdata = 0;
  logic [15:0] sw_ctrl_wdata = 0;
  logic [23:0] sw_addr_wdata = 0;
  logic [31:0] stat_q;
  logic [15:0] ctrl_q;
  logic [23:0] exc_addr_q;
  logic        exc_addr_vld, ftz, saz, exc_unmasked;
  logic [6:0]  exc_mask;
  logic [1:0]  round_mode;

  fpu_csr u_fpu_csr (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic done = 0;

  typedef struct {
    logic [31:0] stat;
    logic [15:0] ctrl;
    logic [23:0] addr;
    logic        vld;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_stat = 0;
  logic [15:0] m_ctrl = 16'h007F;
  logic [23:0] m_addr = 0;
  logic        m_vld = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input logic v, input logic [6:0] f, input logic [23:0] a,
                      input logic ic, input logic [3:0] c, input logic it, input logic [4:0] t,
                      input logic wl, input logic wh, input logic [31:0] sd,
                      input logic wc, input logic [15:0] cd,
                      input logic wa, input logic [23:0] ad);
    exp_t e;
    logic [31:0] ns;
    @(negedge clk);
    rt_valid = v; rt_flags = f; rt_addr = a; rt_is_cmp = ic; rt_cmp = c;
    rt_is_tst = it; rt_tst = t; sw_stat_wr_lo = wl; sw_stat_wr_hi = wh;
    sw_stat_wdata = sd; sw_ctrl_wr = wc; sw_ctrl_wdata = cd;
    sw_addr_wr = wa; sw_addr_wdata = ad;
    #1;
    chk({tag, " R10 unmasked"}, 64'(exc_unmasked), 64'(v && |(f & ~m_ctrl[6:0])));
    ns = m_stat;
    if (v) begin
      ns[6:0] = f;
      ns[14:8] = m_stat[14:8] | f;
      if (ic) ns[19:16] = c;
      if (it) ns[28:24] = t;
    end
    if (wl) begin ns[6:0] = sd[6:0]; ns[14:8] = sd[14:8]; end
    if (wh) begin ns[19:16] = sd[19:16]; ns[28:24] = sd[28:24]; end
    m_stat = ns;
    if (wc) m_ctrl = cd & 16'h0FFF;
    if (wa) begin m_addr = ad; m_vld = 0; end
    else if (!m_vld && v && |f) begin m_addr = a; m_vld = 1; end
    e.stat = m_stat; e.ctrl = m_ctrl; e.addr = m_addr; e.vld = m_vld; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic rt(input string tag, input logic [6:0] f, input logic [23:0] a);
    step(tag, 1, f, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: compares each cycle's register outputs with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " stat"}, 64'(stat_q), 64'(e.stat));
        chk({e.tag, " ctrl"}, 64'(ctrl_q), 64'(e.ctrl));
        chk({e.tag, " addr"}, 64'(exc_addr_q), 64'(e.addr));
        chk({e.tag, " vld"}, 64'(exc_addr_vld), 64'(e.vld));
        chk({e.tag, " fields R4"}, 64'({exc_mask, round_mode, ftz, saz}),
            64'({e.ctrl[6:0], e.ctrl[9:8], e.ctrl[10], e.ctrl[11]}));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R4 reset ctrl", 64'(ctrl_q), 64'h007F);
    chk("R5 reset stat", 64'(stat_q), 0);
    chk("R5 reset vld", 64'({exc_addr_vld, exc_addr_q}), 0);
    rt("R5 first capture", 7'h05, 24'hA0_0001);
    rt("R2 sticky or", 7'h12, 24'hA0_0002);
    rt("R1 clean retire", 7'h00, 24'hA0_0003);
    step("R1 idle hold", 0, 7'h7F, 24'h1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 compare", 1, 0, 24'h4, 1, 4'hA, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 test", 1, 0, 24'h5, 0, 4'h3, 1, 5'h15, 0, 0, 0, 0, 0, 0, 0);
    step("R3 no strobe", 1, 0, 24'h6, 0, 4'h3, 0, 5'h0A, 0, 0, 0, 0, 0, 0, 0);
    step("R9 ctrl write", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFF0, 0, 0);
    rt("R10 unmasked flag", 7'h02, 24'h7);
    rt("R10 masked flag", 7'h40, 24'h8);
    step("R7 lo write", 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_8080, 0, 0, 0, 0);
    step("R8 hi write retire", 1, 7'h11, 24'h9, 1, 4'h5, 1, 5'h03, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R8 lo write retire", 1, 7'h44, 24'hA, 1, 4'h6, 0, 0, 1, 0, 32'h0000_0201, 0, 0, 0, 0);
    step("R9 hi unused", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hE0F0_0000, 0, 0, 0, 0);
    step("R6 rearm wins", 1, 7'h01, 24'hBB_BBBB, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 24'h12_3456);
    rt("R6 recapture", 7'h08, 24'hCC_CCCC);
    rt("R5 later holds", 7'h08, 24'hDD_DDDD);
    step("R4 ctrl modes", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0655, 0, 0);
    step("R10 idle", 0, 7'h7F, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule